// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures a low-frequency oscillator against the fast reference clock it runs on. Three candidate slow sources come in as plain signals. A two-bit select picks one, and the block resynchronises it into the reference domain, where its rising edges are detected. Software sets a window length in slow-clock cycles and raises the start control. The block waits for the first slow edge and then counts reference cycles until the requested number of further slow edges has passed. The count is reported on `value` and `ready` goes high.

A separate elapsed-cycle counter runs from the start of each measurement. If it reaches the programmed threshold before the window closes, the run ends with `timeout` set instead of `ready`. A dead or very slow oscillator therefore cannot hang the caller. When the cycling control is set, windows follow back to back and each one refreshes `value`. Writing a threshold of 1 stops such a run at once.

The controller has five named states. IDLE waits for a start edge. ARM waits for the first slow edge. COUNT accumulates cycles. DONE holds a result. TMO holds an abort.

The transitions are:
- start-rise goes from any state to ARM.
- start-low goes from any state to IDLE.
- first-edge goes from ARM to COUNT.
- window-end goes from COUNT to DONE, or stays in COUNT when cycling.
- threshold-hit goes from ARM or COUNT to TMO.

Top module: `slowclk_meter`

## Requirements
- R1: `src_sel` selects the clock under test: 0 = RC slow input, 1 = RC fast input, 2 = 32 kHz input. Code 3 selects a constant low, so any measurement with code 3 ends in timeout.
- R2: A window spans `win_cycles` slow-clock periods, starting at a slow rising edge. `value` equals `win_cycles` times the slow period in reference cycles, within ±2. A `win_cycles` of 0 behaves as 1.
- R3: A measurement is launched only by a 0-to-1 transition of `start`. Keeping `start` high after a result leaves `value` and `ready` unchanged.
- R4: `ready` rises only in the cycle after the slow edge that closes the window. `value` then holds that window's count.
- R5: If the elapsed reference-cycle count since launch reaches `tmo_thresh` before the window closes, `timeout` is set and `ready` stays low. For a stopped clock this happens thresh+1 cycles after `start` rises (±2). When the window closes in the same cycle that the threshold is reached, completion wins.
- R6: While `cycling` is set, a new window starts at the edge that closes the previous one. `ready` stays high and `value` is refreshed with each window's count, using the current `win_cycles`.
- R7: Writing `tmo_thresh` = 1 during a cycling run raises `timeout` and drops `ready` within 4 cycles.
- R8: While `start` is low, `ready` and `timeout` are low from the next cycle on and the run is abandoned.
- R9: The result saturates at all ones of its width (parameter `CNT_W`) instead of wrapping.
- R10: `ready` and `timeout` are never high together.
- R11: After reset, `ready`, `timeout` and `value` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_rc_slow | input | 1 | RC slow oscillator (source 0) |
| osc_rc_fast | input | 1 | RC fast oscillator (source 1) |
| osc_32k | input | 1 | 32 kHz path (source 2) |
| src_sel | input | 2 | Clock-under-test select |
| win_cycles | input | WIN_W | Window length in slow cycles |
| tmo_thresh | input | TMO_W | Timeout threshold in reference cycles |
| start | input | 1 | Launch on rising edge; low clears status |
| cycling | input | 1 | Back-to-back measurement mode |
| ready | output | 1 | Result valid |
| timeout | output | 1 | Measurement aborted, result invalid |
| value | output | CNT_W | Reference cycles counted in the window |

## Verification
The embedded properties check on every cycle the following:
- `ready` and `timeout` never overlap.
- `ready` can only rise right after a detected slow edge.
- A low `start` clears both flags.
- A synchronised edge pulse lasts one cycle.
- A counter at its ceiling holds there.

Some behaviours can only be shown by the bench's scenarios:
- The count itself matches window times ratio.
- Each source code routes the intended input.
- A stopped oscillator times out near the threshold.
- Cycling refreshes the result when the window length changes.
- A threshold of 1 cuts a cycling run short.

// File: rtl/slowclk_pkg.sv
package slowclk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_COUNT,
        ST_DONE,
        ST_TMO
    } meter_state_t;

    localparam logic [1:0] SRC_RC_SLOW = 2'd0;
    localparam logic [1:0] SRC_RC_FAST = 2'd1;
    localparam logic [1:0] SRC_32K     = 2'd2;

endpackage

// File: rtl/slowclk_edge_sync.sv
// Selects the clock under test, resynchronises it and flags rising edges.
module slowclk_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_rc_slow,
    input  logic       osc_rc_fast,
    input  logic       osc_32k,
    input  logic [1:0] src_sel,
    output logic       edge_o
);
    import slowclk_pkg::*;

    localparam int DEPTH = SYNC_STAGES + 1;

    logic          picked;
    logic [DEPTH-1:0] shreg;

    always_comb begin
        unique case (src_sel)
            SRC_RC_SLOW: picked = osc_rc_slow;
            SRC_RC_FAST: picked = osc_rc_fast;
            SRC_32K:     picked = osc_32k;
            default:     picked = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[DEPTH-2:0], picked};
    end

    assign edge_o = shreg[DEPTH-2] & ~shreg[DEPTH-1];

    // R2: a detected edge is a single-cycle event
    assert_edge_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/slowclk_satcnt.sv
// Saturating up-counter with synchronous clear (clear has priority).
module slowclk_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (clr)               cnt <= '0;
        else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
    end

    // R9: a counter at its ceiling stays there until cleared
    assert_hold_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && !clr) |=> cnt == TOP);

endmodule

// File: rtl/slowclk_ctrl.sv
// Measurement sequencer: launch, window tracking, timeout and cycling.
module slowclk_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cycling_i,
    input  logic edge_i,
    input  logic win_last_i,
    input  logic tmo_hit_i,
    output logic clr_run_o,
    output logic clr_tmo_o,
    output logic clr_val_o,
    output logic run_inc_o,
    output logic edge_inc_o,
    output logic latch_o,
    output logic ready_o,
    output logic timeout_o
);
    import slowclk_pkg::*;

    meter_state_t state, nxt;
    logic         start_q;
    logic         start_rise;
    logic         win_end;

    assign start_rise = start_i & ~start_q;
    assign win_end    = (state == ST_COUNT) && edge_i && win_last_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            state   <= nxt;
            start_q <= start_i;
        end
    end

    always_comb begin
        nxt = state;
        if (!start_i) begin
            nxt = ST_IDLE;
        end else if (start_rise) begin
            nxt = ST_ARM;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_IDLE;
                ST_ARM: begin
                    if (tmo_hit_i)   nxt = ST_TMO;
                    else if (edge_i) nxt = ST_COUNT;
                end
                ST_COUNT: begin
                    if (win_end)        nxt = cycling_i ? ST_COUNT : ST_DONE;
                    else if (tmo_hit_i) nxt = ST_TMO;
                end
                ST_DONE:  nxt = ST_DONE;
                ST_TMO:   nxt = ST_TMO;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        run_inc_o  = (state == ST_ARM) || (state == ST_COUNT);
        edge_inc_o = (state == ST_COUNT) && edge_i;
        latch_o    = start_i && !start_rise && win_end;
        clr_val_o  = start_rise;
        clr_tmo_o  = start_rise || latch_o;
        clr_run_o  = start_rise || latch_o || ((state == ST_ARM) && edge_i);
        timeout_o  = (state == ST_TMO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    ready_o <= 1'b0;
        else if (!start_i || start_rise || nxt == ST_TMO) ready_o <= 1'b0;
        else if (latch_o)                              ready_o <= 1'b1;
    end

    // R10: result and abort flags are exclusive
    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && timeout_o));

    // R4: ready only rises right after a slow edge
    assert_ready_after_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(edge_i));

    // R8: a low start clears both status flags
    assert_start_low_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!ready_o && !timeout_o));

endmodule

// File: rtl/slowclk_meter.sv
// Top: measures a selected slow oscillator in reference-clock cycles.
module slowclk_meter #(
    parameter int WIN_W = 16,
    parameter int CNT_W = 24,
    parameter int TMO_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_rc_slow,
    input  logic             osc_rc_fast,
    input  logic             osc_32k,
    input  logic [1:0]       src_sel,
    input  logic [WIN_W-1:0] win_cycles,
    input  logic [TMO_W-1:0] tmo_thresh,
    input  logic             start,
    input  logic             cycling,
    output logic             ready,
    output logic             timeout,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic             slow_edge;
    logic             clr_run, clr_tmo, clr_val, run_inc, edge_inc, latch;
    logic [CNT_W-1:0] run_cnt;
    logic [TMO_W-1:0] elapsed;
    logic [WIN_W-1:0] edges_seen;
    logic             win_last, tmo_hit;

    slowclk_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_rc_slow (osc_rc_slow),
        .osc_rc_fast (osc_rc_fast),
        .osc_32k     (osc_32k),
        .src_sel     (src_sel),
        .edge_o      (slow_edge)
    );

    slowclk_satcnt #(.W(CNT_W)) u_run (
        .clk (clk), .rst_n (rst_n), .clr (clr_run), .inc (run_inc), .cnt (run_cnt)
    );

    slowclk_satcnt #(.W(TMO_W)) u_elapsed (
        .clk (clk), .rst_n (rst_n), .clr (clr_tmo), .inc (run_inc), .cnt (elapsed)
    );

    slowclk_satcnt #(.W(WIN_W)) u_edges (
        .clk (clk), .rst_n (rst_n), .clr (clr_run), .inc (edge_inc), .cnt (edges_seen)
    );

    assign win_last = ({1'b0, edges_seen} + (WIN_W+1)'(1)) >= {1'b0, win_cycles};
    assign tmo_hit  = ({1'b0, elapsed} + (TMO_W+1)'(1)) >= {1'b0, tmo_thresh};

    slowclk_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cycling_i  (cycling),
        .edge_i     (slow_edge),
        .win_last_i (win_last),
        .tmo_hit_i  (tmo_hit),
        .clr_run_o  (clr_run),
        .clr_tmo_o  (clr_tmo),
        .clr_val_o  (clr_val),
        .run_inc_o  (run_inc),
        .edge_inc_o (edge_inc),
        .latch_o    (latch),
        .ready_o    (ready),
        .timeout_o  (timeout)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       value <= '0;
        else if (clr_val) value <= '0;
        else if (latch)   value <= (run_cnt == CNT_TOP) ? CNT_TOP : run_cnt + 1'b1;
    end

    // R3: without a new launch or latch the result is frozen
    assert_value_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_val && !latch) |=> $stable(value));

endmodule

// File: tb/test_slowclk_meter.sv
module test_slowclk_meter;

    localparam int WIN_W = 16;
    localparam int CNT_W = 24;
    localparam int TMO_W = 24;
    localparam int P_SLOW = 14;
    localparam int P_FAST = 4;
    localparam int P_32K  = 20;
    localparam int NVEC = 6;
    localparam int VEC_SEL [NVEC] = '{0, 1, 2, 0, 1, 2};
    localparam int VEC_WIN [NVEC] = '{4, 10, 3, 1, 0, 8};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_rc_slow = 1'b0, osc_rc_fast = 1'b0, osc_32k = 1'b0;
    logic en_32k = 1'b1;
    logic [1:0] src_sel = 2'd0;
    logic [WIN_W-1:0] win_cycles = '0;
    logic [TMO_W-1:0] tmo_thresh = '0;
    logic start = 1'b0, cycling = 1'b0;
    logic ready, timeout, ready_n, timeout_n;
    logic [CNT_W-1:0] value;
    logic [5:0] value_n;

    int checks = 0;
    int fails = 0;
    int waited;

    always #5 clk = ~clk;
    initial forever #70  osc_rc_slow = ~osc_rc_slow;
    initial forever #20  osc_rc_fast = ~osc_rc_fast;
    initial forever #100 osc_32k = en_32k ? ~osc_32k : 1'b0;

    slowclk_meter #(.WIN_W(WIN_W), .CNT_W(CNT_W), .TMO_W(TMO_W)) i_slowclk_meter (
        .clk (clk), .rst_n (rst_n), .osc_rc_slow (osc_rc_slow), .osc_rc_fast (osc_rc_fast),
        .osc_32k (osc_32k), .src_sel (src_sel), .win_cycles (win_cycles),
        .tmo_thresh (tmo_thresh), .start (start), .cycling (cycling),
        .ready (ready), .timeout (timeout), .value (value)
    );

    slowclk_meter #(.WIN_W(WIN_W), .CNT_W(6), .TMO_W(TMO_W)) i_slowclk_meter_narrow (
        .clk (clk), .rst_n (rst_n), .osc_rc_slow (osc_rc_slow), .osc_rc_fast (osc_rc_fast),
        .osc_32k (osc_32k), .src_sel (src_sel), .win_cycles (win_cycles),
        .tmo_thresh (tmo_thresh), .start (start), .cycling (cycling),
        .ready (ready_n), .timeout (timeout_n), .value (value_n)
    );

    function automatic int period_of(input int sel);
        case (sel)
            0: return P_SLOW;
            1: return P_FAST;
            default: return P_32K;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(input int sel, input int win, input int thr);
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        src_sel = 2'(sel);
        win_cycles = WIN_W'(win);
        tmo_thresh = TMO_W'(thr);
        start = 1'b1;
        waited = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            waited++;
            if (ready || timeout) break;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!ready && !timeout && value == 0, "R11", {ready, timeout}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!ready && !timeout && value == 0, "R11", value, 0);

        // R1 R2 R4: table of sources and window lengths
        for (int v = 0; v < NVEC; v++) begin
            int weff;
            int exp;
            weff = (VEC_WIN[v] == 0) ? 1 : VEC_WIN[v];
            exp = weff * period_of(VEC_SEL[v]);
            launch(VEC_SEL[v], VEC_WIN[v], 100000);
            check(ready && !timeout, "R4", ready, 1);
            check(int'(value) >= exp - 2 && int'(value) <= exp + 2, "R2", value, exp);
        end

        // R3: holding start high does not relaunch
        begin
            logic [CNT_W-1:0] held;
            held = value;
            repeat (60) @(negedge clk);
            check(ready && value == held, "R3", value, held);
        end

        // R1: code 3 selects nothing, so the run times out
        launch(3, 2, 300);
        check(timeout && !ready, "R1", timeout, 1);

        // R5: a stopped 32 kHz input times out after thresh+1 cycles
        en_32k = 1'b0;
        launch(2, 2, 200);
        check(timeout && !ready, "R5", {ready, timeout}, 1);
        check(waited >= 199 && waited <= 203, "R5", waited, 201);
        en_32k = 1'b1;

        // R8: clearing start clears the flags
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(!ready && !timeout, "R8", {ready, timeout}, 0);

        // R9: the narrow instance saturates (8 * 14 = 112 > 63)
        launch(0, 8, 100000);
        check(ready && int'(value) >= 110 && int'(value) <= 114, "R9", value, 112);
        check(ready_n && value_n == 6'h3F, "R9", value_n, 63);

        // R6: cycling refreshes the value when the window length changes
        cycling = 1'b1;
        launch(1, 5, 100000);
        check(ready && int'(value) >= 18 && int'(value) <= 22, "R6", value, 20);
        win_cycles = WIN_W'(10);
        repeat (100) @(negedge clk);
        check(ready && int'(value) >= 38 && int'(value) <= 42, "R6", value, 40);

        // R7: threshold 1 aborts the cycling run
        tmo_thresh = TMO_W'(1);
        waited = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            waited++;
            if (timeout) break;
        end
        check(timeout && !ready && waited <= 4, "R7", waited, 4);
        check(!(ready && timeout), "R10", {ready, timeout}, 0);
        cycling = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule